// File: doc/BRIEF.md
# Fully Associative Translation Buffer

This block keeps a small set of recent address translations, each linking a virtual page number to a physical frame number and a field of access-rights bits. A requester presents a page number on the lookup port. In the same cycle it receives a hit indication, the matching frame number and the rights bits. Every stored entry is compared in parallel, so the result needs no clock edge.

When a lookup misses, the block raises a miss flag. An external table walker then resolves the translation over as many cycles as it needs and writes the result back through the fill port. A fill that repeats a page number already held rewrites that entry in place. Otherwise the fill takes the lowest-numbered empty slot, and when no slot is empty it evicts the slot named by a rotating pointer. A single flush input empties the whole buffer in one cycle.

Top module: `xlat_buf`

## Requirements
- R1: After reset every entry is empty, so no lookup hits.
- R2: While `lk_req` is high and a valid entry holds `lk_vpn`, `lk_hit` is 1 in the same cycle, and `lk_pfn` and `lk_perm` carry that entry's frame number and rights bits.
- R3: While `lk_req` is high and no valid entry holds `lk_vpn`, `lk_miss` is 1 and `lk_hit` is 0. While `lk_req` is low, both flags are 0. Whenever `lk_hit` is 0, `lk_pfn` and `lk_perm` are all zeros.
- R4: A fill (`fill_en` high and `flush_all` low) installs its translation at the clock edge, and lookups from the next cycle on see it.
- R5: A fill whose page number is not already held goes to the lowest-indexed invalid entry when any entry is invalid.
- R6: When every entry is valid, a fill of a new page number replaces the entry chosen by a rotating pointer. The pointer is 0 after reset and advances by one, wrapping from ENTRIES-1 to 0, only on such a replacement. A flush leaves it unchanged.
- R7: A fill whose page number matches a valid entry overwrites that entry, so at most one entry ever matches a page number. Such a fill does not move the pointer.
- R8: `flush_all` invalidates every entry at the next edge. A fill in the same cycle as a flush is discarded.
- R9: A lookup in the same cycle as a fill sees the contents from before the fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Page number to translate |
| lk_hit | output | 1 | Lookup found a valid match |
| lk_miss | output | 1 | Lookup requested with no match |
| lk_pfn | output | PFN_W | Frame number of the match, zero otherwise |
| lk_perm | output | PERM_W | Rights bits of the match, zero otherwise |
| fill_en | input | 1 | Install a translation |
| fill_vpn | input | VPN_W | Page number of the fill |
| fill_pfn | input | PFN_W | Frame number of the fill |
| fill_perm | input | PERM_W | Rights bits of the fill |
| flush_all | input | 1 | Invalidate every entry |

## Verification
The bench fills the buffer past capacity, both from reset and after a flush. A pointer that restarted on flush, or that advanced on an in-place rewrite, would then evict the wrong translation, and a later lookup would hit where a miss is due or the reverse. It rewrites a page number that is already held. A design that allocated a fresh slot here would hold a duplicate and OR two frame numbers together on a later lookup. It also issues a lookup of the page being filled in the same cycle, which must miss, and a fill alongside a flush, which must leave nothing behind. A long random phase over a narrow page range drives hits, rewrites, evictions and flushes together.

// File: rtl/xlat_buf.sv
module xlat_buf #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int PERM_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_req,
  input  logic [VPN_W-1:0]  lk_vpn,
  output logic              lk_hit,
  output logic              lk_miss,
  output logic [PFN_W-1:0]  lk_pfn,
  output logic [PERM_W-1:0] lk_perm,
  input  logic              fill_en,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [PFN_W-1:0]  fill_pfn,
  input  logic [PERM_W-1:0] fill_perm,
  input  logic              flush_all
);
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IW-1:0] LAST = IW'(ENTRIES - 1);

  logic [ENTRIES-1:0] valid_q, lk_match, fill_match;
  logic [VPN_W-1:0]   vpn_q  [ENTRIES];
  logic [PFN_W-1:0]   pfn_q  [ENTRIES];
  logic [PERM_W-1:0]  perm_q [ENTRIES];
  logic [IW-1:0]      rr_q, free_idx, dup_idx, victim;
  logic               any_free, fill_dup, do_fill, use_rr;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign lk_match[g]   = valid_q[g] && (vpn_q[g] == lk_vpn);
    assign fill_match[g] = valid_q[g] && (vpn_q[g] == fill_vpn);
  end

  assign lk_hit  = lk_req && (|lk_match);
  assign lk_miss = lk_req && !(|lk_match);

  always_comb begin
    lk_pfn  = '0;
    lk_perm = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_req && lk_match[i]) begin
        lk_pfn  = lk_pfn | pfn_q[i];
        lk_perm = lk_perm | perm_q[i];
      end
    end
  end

  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    dup_idx  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_q[i]) begin
        any_free = 1'b1;
        free_idx = IW'(i);
      end
      if (fill_match[i]) dup_idx = IW'(i);
    end
  end

  assign fill_dup = |fill_match;
  assign do_fill  = fill_en && !flush_all;
  assign use_rr   = do_fill && !fill_dup && !any_free;
  assign victim   = fill_dup ? dup_idx : (any_free ? free_idx : rr_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      rr_q    <= '0;
    end else begin
      if (flush_all) valid_q <= '0;
      else if (do_fill) valid_q[victim] <= 1'b1;
      if (use_rr) rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_fill) begin
      vpn_q[victim]  <= fill_vpn;
      pfn_q[victim]  <= fill_pfn;
      perm_q[victim] <= fill_perm;
    end
  end

  assert_single_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match));

  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> (valid_q == '0));

  assert_fill_grows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (do_fill && !fill_dup && any_free) |=>
      ($countones(valid_q) == $past($countones(valid_q)) + 1));

  assert_ptr_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !use_rr |=> $stable(rr_q));

  assert_zero_on_nohit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_pfn == '0 && lk_perm == '0));

  assert_fill_seen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (do_fill && lk_req && lk_vpn == fill_vpn) |=>
      ($stable(lk_vpn) && $stable(lk_req)) |-> lk_hit);
endmodule

// File: tb/xlat_buf_bench.sv
module xlat_buf_bench;
  localparam int ENT = 16, VW = 20, PW = 20, RW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lk_req = 0, fill_en = 0, flush_all = 0;
  logic [VW-1:0] lk_vpn = '0, fill_vpn = '0;
  logic [PW-1:0] fill_pfn = '0;
  logic [RW-1:0] fill_perm = '0;
  logic lk_hit, lk_miss;
  logic [PW-1:0] lk_pfn;
  logic [RW-1:0] lk_perm;

  int vectors = 0, errors = 0;
  bit m_val [ENT];
  int m_vpn [ENT], m_pfn [ENT], m_perm [ENT];
  int m_ptr = 0;

  always #10 clk = ~clk;

  xlat_buf #(.ENTRIES(ENT), .VPN_W(VW), .PFN_W(PW), .PERM_W(RW)) u_xlat_buf (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_vpn(lk_vpn),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_pfn(lk_pfn), .lk_perm(lk_perm),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
    .fill_perm(fill_perm), .flush_all(flush_all));

  task automatic apply(string tag, bit req, int vpn, bit fe, int fv, int fp, int fr, bit fl);
    int e_hit, e_pfn, e_perm, slot;
    @(negedge clk);
    lk_req = req; lk_vpn = VW'(vpn); fill_en = fe; fill_vpn = VW'(fv);
    fill_pfn = PW'(fp); fill_perm = RW'(fr); flush_all = fl;
    #2;
    e_hit = 0; e_pfn = 0; e_perm = 0;
    for (int i = 0; i < ENT; i++)
      if (req && m_val[i] && m_vpn[i] == vpn) begin e_hit = 1; e_pfn = m_pfn[i]; e_perm = m_perm[i]; end
    vectors++;
    if (lk_hit !== 1'(e_hit) || lk_miss !== 1'(req && !e_hit) ||
        lk_pfn !== PW'(e_pfn) || lk_perm !== RW'(e_perm)) begin
      errors++;
      $display("FAIL %s vpn=%0d: hit/miss/pfn/perm got %b/%b/%0d/%0d expected %0d/%0d/%0d/%0d",
               tag, vpn, lk_hit, lk_miss, lk_pfn, lk_perm, e_hit, req && !e_hit, e_pfn, e_perm);
    end
    if (fl) begin
      for (int i = 0; i < ENT; i++) m_val[i] = 0;
    end else if (fe) begin
      slot = -1;
      for (int i = 0; i < ENT; i++) if (m_val[i] && m_vpn[i] == fv) slot = i;
      if (slot < 0) for (int i = ENT - 1; i >= 0; i--) if (!m_val[i]) slot = i;
      if (slot < 0) begin slot = m_ptr; m_ptr = (m_ptr + 1) % ENT; end
      m_val[slot] = 1; m_vpn[slot] = fv; m_pfn[slot] = fp; m_perm[slot] = fr;
    end
  endtask

  task automatic look(string tag, int vpn);
    apply(tag, 1, vpn, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < ENT; i++) m_val[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    look("R1", 5);
    look("R1", 0);
    apply("R3", 0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < ENT; i++)
      apply("R9", 1, 100 + i, 1, 100 + i, 3 * i + 7, i % 16, 0);
    for (int i = 0; i < ENT; i++) look("R2", 100 + i);
    apply("R3", 0, 101, 0, 0, 0, 0, 0);
    look("R3", 999);
    apply("R7", 1, 103, 1, 103, 555, 9, 0);
    look("R7", 103);
    apply("R6", 0, 0, 1, 200, 1200, 1, 0);
    apply("R6", 0, 0, 1, 201, 1201, 2, 0);
    look("R6", 100); look("R6", 101); look("R6", 102); look("R6", 200); look("R6", 201);
    apply("R8", 1, 200, 1, 300, 1300, 3, 1);
    look("R8", 200); look("R8", 300); look("R8", 105);
    for (int i = 0; i < ENT + 2; i++) apply("R5", 0, 0, 1, 400 + i, 2000 + i, i % 16, 0);
    for (int i = 0; i < ENT + 2; i++) look("R6", 400 + i);
    apply("R4", 0, 0, 1, 500, 77, 5, 0);
    look("R4", 500);
    for (int k = 0; k < 3000; k++) begin
      int v = int'($urandom_range(0, 39));
      bit fe = ($urandom_range(0, 2) == 0);
      bit fl = ($urandom_range(0, 49) == 0);
      apply("R2", $urandom_range(0, 3) != 0, v, fe, int'($urandom_range(0, 39)),
            int'($urandom_range(0, 65535)), int'($urandom_range(0, 15)), fl);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule